// File: doc/BRIEF.md
# Quad DAC Register Control Core

This block is the digital control core of a four-channel, 16-bit voltage DAC. A serial front end, outside this block, shifts in frames and presents each decoded frame as one command beat: an opcode, a channel address and a 16-bit data word. Each channel is double-buffered. A staging register takes new codes. An output register drives the converter. Codes move from staging to output in one of three ways: a combined write-and-update command, a software load command that takes a channel mask, or a hardware load strobe that acts on the channels enabled in a mask held in the block.

An asynchronous clear pin forces every output register to a code chosen in software: zero scale, midscale or full scale. The pin is synchronised inside the block. While it is active, clear wins over every write and load, and it leaves the staging registers untouched. Each channel also holds a 2-bit power-down mode. The reset value of all codes is zero scale or midscale, chosen by a configuration pin.

The command port is a valid/ready stream. A beat transfers on a rising clock edge when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low during reset and for as long as the synchronised clear is active. It is high at every other time, so the block never stalls a sender for any other reason. A sender that finds `cmd_ready` low must hold its beat; a beat that is dropped while ready is low is simply not taken.

Top module: `quad_dac_ctrl`

## Requirements
- R1: While `rst_n` is low, every staging and output code resets to 0x0000 if `por_mid` is 0, or to 0x8000 if it is 1. All power-down modes reset to 00. The hardware load mask resets to 4'b1111 and the clear-code select resets to 00. `cmd_ready` is low during reset and rises one cycle after `rst_n` goes high.
- R2: Opcode 1 writes `cmd_data` into the staging register of channel `cmd_ch`. The output code of that channel does not change.
- R3: Opcode 2 writes `cmd_data` into both the staging and the output register of channel `cmd_ch`. The new code appears on `dac_code` after the accepting edge.
- R4: When `ldac` is high at a clock edge, each channel i whose bit i of the hardware load mask is 1 copies its staging code to its output. A channel whose mask bit is 0 keeps its output. Opcode 4 sets the hardware load mask from `cmd_data[3:0]`, where bit i is channel i.
- R5: Opcode 3 copies staging to output for each channel i whose bit `cmd_data[i]` is 1. No other channel changes.
- R6: Opcode 6 sets the clear-code select from `cmd_data[1:0]`. The encodings are 00 = 0x0000, 01 = 0x8000, 10 = 0xFFFF, and 11 = 0x0000.
- R7: A low level on `clr_n` passes through a two-stage synchroniser. One edge later, every output code equals the selected clear code, and it stays there while the pin is low. During that time `ldac` and commands have no effect and the staging registers keep their contents. After the pin is released, the outputs keep the clear code.
- R8: Opcode 5 sets the power-down mode of channel `cmd_ch` to `cmd_data[1:0]`. The encodings are 00 = normal, 01 = 1 kΩ to ground, 10 = 100 kΩ to ground, and 11 = three-state. `pd_mode[2i+1:2i]` belongs to channel i.
- R9: Opcodes 0 and 7 to 15 change nothing. A beat offered with `cmd_valid` low changes nothing.
- R10: `cmd_ready` is low exactly while reset or the synchronised clear is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, acts as the power-on reset |
| por_mid | input | 1 | Reset code select: 0 = zero scale, 1 = midscale |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Command beat accepted when high with valid |
| cmd_op | input | 4 | Opcode |
| cmd_ch | input | 2 | Channel address |
| cmd_data | input | 16 | Data word |
| ldac | input | 1 | Hardware load strobe, synchronous, active high |
| clr_n | input | 1 | Asynchronous clear, active low |
| dac_code | output | 64 | Output codes, channel i at bits [16i+15:16i] |
| pd_mode | output | 8 | Power-down modes, channel i at bits [2i+1:2i] |

## Verification
The bench sweeps the hardware load strobe and the software load command through all sixteen channel masks. A design that reversed the mask sense, or that let the strobe reach masked channels, would move outputs that should hold. Clear is driven with all four select codes while load strobes and update commands are offered. A design that let a load win over clear, or that overwrote the staging registers, would show the wrong output during the clear or would restore the wrong codes at the following software load. Staging-only writes and unknown opcodes are followed by checks that the outputs have not moved. Both reset codes are covered by applying reset twice.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_WR_STAGE = 4'd1,
    OP_WR_BOTH  = 4'd2,
    OP_SW_LOAD  = 4'd3,
    OP_LD_MASK  = 4'd4,
    OP_SET_PD   = 4'd5,
    OP_CLR_SEL  = 4'd6
  } dac_op_e;

  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_1K     = 2'b01,
    PD_100K   = 2'b10,
    PD_TRI    = 2'b11
  } pd_mode_e;

  localparam int PD_W  = 2;
  localparam int SEL_W = 2;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import quad_dac_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            fire,
  input  logic [3:0]      op,
  input  logic [CH_W-1:0] ch,
  input  logic [NCH-1:0]  sel_mask,
  output logic [NCH-1:0]  wr_stage,
  output logic [NCH-1:0]  wr_both,
  output logic [NCH-1:0]  sw_load,
  output logic [NCH-1:0]  pd_we,
  output logic            mask_we,
  output logic            csel_we
);
  logic is_stage, is_both, is_load, is_pd;

  always_comb begin
    is_stage = fire && (op == OP_WR_STAGE);
    is_both  = fire && (op == OP_WR_BOTH);
    is_load  = fire && (op == OP_SW_LOAD);
    is_pd    = fire && (op == OP_SET_PD);
    mask_we  = fire && (op == OP_LD_MASK);
    csel_we  = fire && (op == OP_CLR_SEL);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    assign hit         = (ch == CH_W'(i));
    assign wr_stage[i] = (is_stage || is_both) && hit;
    assign wr_both[i]  = is_both && hit;
    assign sw_load[i]  = is_load && sel_mask[i];
    assign pd_we[i]    = is_pd && hit;
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import quad_dac_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   por_code,
  input  logic            clr,
  input  logic [DW-1:0]   clr_code,
  input  logic            wr_stage,
  input  logic            wr_both,
  input  logic            load,
  input  logic [DW-1:0]   wr_data,
  input  logic            pd_we,
  input  logic [PD_W-1:0] pd_in,
  output logic [DW-1:0]   dac_q,
  output logic [PD_W-1:0] pd_q
);
  logic [DW-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= por_code;
    else if (wr_stage && !clr) stage_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dac_q <= por_code;
    else if (clr)     dac_q <= clr_code;
    else if (wr_both) dac_q <= wr_data;
    else if (load)    dac_q <= stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pd_q <= PD_NORMAL;
    else if (pd_we) pd_q <= pd_in;
  end

  AST_CLR_FORCES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> dac_q == $past(clr_code)); // R7
  AST_CLR_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> $stable(stage_q)); // R7
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr && !wr_both) |=> dac_q == $past(stage_q)); // R4
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr && !wr_both) |=> $stable(dac_q)); // R2
  AST_PD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_we |=> $stable(pd_q)); // R8
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import quad_dac_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_mid,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [3:0]          cmd_op,
  input  logic [1:0]          cmd_ch,
  input  logic [DW-1:0]       cmd_data,
  input  logic                ldac,
  input  logic                clr_n,
  output logic [NCH*DW-1:0]   dac_code,
  output logic [NCH*PD_W-1:0] pd_mode
);
  localparam int CH_W = $clog2(NCH);
  localparam logic [DW-1:0] MID_CODE  = DW'(1) << (DW-1);
  localparam logic [DW-1:0] FULL_CODE = '1;

  logic             clr_s, ready_q, fire, mask_we, csel_we;
  logic [NCH-1:0]   ld_mask_q, wr_stage, wr_both, sw_load, pd_we;
  logic [SEL_W-1:0] csel_q;
  logic [DW-1:0]    clr_code, por_code;

  dac_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(clk), .rst_n(rst_n), .async_in(!clr_n), .sync_out(clr_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign cmd_ready = ready_q && !clr_s;
  assign fire      = cmd_valid && cmd_ready;

  dac_cmd_decode #(.NCH(NCH), .CH_W(CH_W)) u_dec (
    .fire(fire), .op(cmd_op), .ch(cmd_ch[CH_W-1:0]), .sel_mask(cmd_data[NCH-1:0]),
    .wr_stage(wr_stage), .wr_both(wr_both), .sw_load(sw_load), .pd_we(pd_we),
    .mask_we(mask_we), .csel_we(csel_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_mask_q <= '1;
      csel_q    <= '0;
    end else begin
      if (mask_we) ld_mask_q <= cmd_data[NCH-1:0];
      if (csel_we) csel_q    <= cmd_data[SEL_W-1:0];
    end
  end

  always_comb begin
    case (csel_q)
      2'b01:   clr_code = MID_CODE;
      2'b10:   clr_code = FULL_CODE;
      default: clr_code = '0;
    endcase
  end

  assign por_code = por_mid ? MID_CODE : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .por_code(por_code),
      .clr(clr_s), .clr_code(clr_code),
      .wr_stage(wr_stage[i]), .wr_both(wr_both[i]),
      .load((ldac && ld_mask_q[i]) || sw_load[i]),
      .wr_data(cmd_data), .pd_we(pd_we[i]), .pd_in(cmd_data[PD_W-1:0]),
      .dac_q(dac_code[i*DW +: DW]), .pd_q(pd_mode[i*PD_W +: PD_W])
    );
  end

  AST_NO_TAKE_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_s) && clr_s |=> $stable(ld_mask_q) && $stable(csel_q)); // R10
  AST_MASK_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> ld_mask_q == $past(cmd_data[NCH-1:0])); // R4
endmodule

// File: tb/quad_dac_ctrl_tb.sv
module quad_dac_ctrl_tb;
  logic        clk = 0, rst_n = 0, por_mid = 0;
  logic        cmd_valid = 0, ldac = 0, clr_n = 1;
  logic        cmd_ready;
  logic [3:0]  cmd_op = 0;
  logic [1:0]  cmd_ch = 0;
  logic [15:0] cmd_data = 0;
  logic [63:0] dac_code;
  logic [7:0]  pd_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_in [4];
  logic [15:0] m_dac[4];
  logic [1:0]  m_pd [4];
  logic [3:0]  m_mask;
  logic [1:0]  m_sel;

  always #2.5 clk = ~clk;

  quad_dac_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .por_mid(por_mid), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_data(cmd_data),
    .ldac(ldac), .clr_n(clr_n), .dac_code(dac_code), .pd_mode(pd_mode)
  );

  function automatic logic [15:0] sel_code(input logic [1:0] s);
    return (s == 2'd1) ? 16'h8000 : (s == 2'd2) ? 16'hFFFF : 16'h0000;
  endfunction

  task automatic chk1(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk1(tag, 32'(dac_code[i*16 +: 16]), 32'(m_dac[i]));
      chk1(tag, 32'(pd_mode[i*2 +: 2]), 32'(m_pd[i]));
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [1:0] ch, input logic [15:0] d);
    cmd_valid = 1; cmd_op = op; cmd_ch = ch; cmd_data = d;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic strobe(input logic [3:0] msk);
    ldac = 1;
    @(posedge clk); @(negedge clk);
    ldac = 0;
    for (int i = 0; i < 4; i++) if (msk[i]) m_dac[i] = m_in[i];
  endtask

  task automatic do_reset(input logic mid);
    rst_n = 0; por_mid = mid;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      m_in[i] = mid ? 16'h8000 : 16'h0; m_dac[i] = m_in[i]; m_pd[i] = 0;
    end
    m_mask = 4'hF; m_sel = 0;
    chk1("R1 ready low in reset", 32'(cmd_ready), 0);
    check_all("R1 reset codes");
    rst_n = 1;
    @(negedge clk);
    chk1("R1 ready after reset", 32'(cmd_ready), 1);
    check_all("R1 codes after reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1'b1);
    do_reset(1'b0);

    // R2 stage-only writes leave outputs; R3 write-and-update
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic [15:0] v;
        v = 16'(p * 16'h2E51 + c * 16'h1111 + (p == 5 ? 16'hFFFF : 0));
        send(4'd1, 2'(c), v); m_in[c] = v;
        check_all("R2 stage write");
      end
      send(4'd2, 2'(p % 4), 16'(~p * 16'h0F0F));
      m_in[p % 4] = 16'(~p * 16'h0F0F); m_dac[p % 4] = m_in[p % 4];
      check_all("R3 write and update");
    end

    // R4 hardware strobe over all masks
    for (int m = 0; m < 16; m++) begin
      send(4'd4, 0, 16'(m)); m_mask = 4'(m);
      for (int c = 0; c < 4; c++) begin
        send(4'd1, 2'(c), 16'(m * 4099 + c * 257 + 1)); m_in[c] = 16'(m * 4099 + c * 257 + 1);
      end
      strobe(m_mask);
      check_all("R4 hardware load");
    end

    // R5 software load over all masks
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 4; c++) begin
        send(4'd1, 2'(c), 16'(m * 3001 + c * 7919)); m_in[c] = 16'(m * 3001 + c * 7919);
      end
      send(4'd3, 0, 16'(m));
      for (int c = 0; c < 4; c++) if (m[c]) m_dac[c] = m_in[c];
      check_all("R5 software load");
    end

    // R8 power-down modes
    for (int c = 0; c < 4; c++)
      for (int md = 0; md < 4; md++) begin
        send(4'd5, 2'(c), 16'(md) | 16'hFFFC); m_pd[c] = 2'(md);
        check_all("R8 power-down mode");
      end

    // R9 ignored opcodes and beats without valid
    for (int op = 0; op < 16; op++) begin
      if (op >= 1 && op <= 6) continue;
      send(4'(op), 2'(op % 4), 16'h5A5A);
      check_all("R9 unknown opcode");
    end
    cmd_op = 4'd2; cmd_ch = 1; cmd_data = 16'h1234;
    @(posedge clk); @(negedge clk);
    check_all("R9 no valid");
    send(4'd3, 0, 16'hF); for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
    check_all("R9 staging untouched by ignored beats");

    // R6/R7/R10 clear with each select code
    for (int s = 0; s < 4; s++) begin
      send(4'd6, 0, 16'(s)); m_sel = 2'(s);
      send(4'd4, 0, 16'hF); m_mask = 4'hF;
      clr_n = 0;
      @(negedge clk); @(negedge clk);
      chk1("R10 ready low in clear", 32'(cmd_ready), 0);
      @(negedge clk);
      for (int c = 0; c < 4; c++) m_dac[c] = sel_code(m_sel);
      check_all("R6 clear code");
      ldac = 1; send(4'd2, 2'(s), 16'h7777); ldac = 0;
      send(4'd1, 2'(s), 16'h3333);
      check_all("R7 clear wins over load and write");
      clr_n = 1;
      repeat (3) @(negedge clk);
      chk1("R10 ready after clear", 32'(cmd_ready), 1);
      check_all("R7 outputs keep clear code");
      send(4'd3, 0, 16'hF); for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
      check_all("R7 staging preserved through clear");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule